// File: doc/BRIEF.md
# I2C Bus-Busy Monitor and Start/Stop Issuer

This block is the control slice of an I2C master that deals with bus ownership. It watches the SDA and SCL lines through a synchroniser and keeps a bus-busy flag. The flag is raised when a start condition appears on the bus and cleared when a stop condition appears. Software asks for a start, a repeated start or a stop with one 8-bit register write. That write combines a busy bit with an active-low issue-enable bit. The block then steps the open-drain SDA and SCL enables through the condition, and each phase lasts a fixed number of clock cycles. Byte transfer, acknowledge handling and arbitration belong to other blocks.

Software can also set the SDA level directly. That field changes only when the guard bit in the same write is 0. A mode input selects I2C format or clocked synchronous format. In clocked synchronous format the busy flag is frozen and issue requests are ignored.

Register layout. The same layout is used for writes and reads:
- bit 7: bus busy.
- bit 6: issue disable. It is active high, is never stored and always reads 1.
- bit 5: SDA level. A 1 releases the line and a 0 pulls it low.
- bit 4: SDA guard. It is write-only and reads 0.
- bits 3 to 0: unused. They read 0.

Top module: `i2c_busctl_top`

## Requirements
- R1: In I2C mode (`modeI2c`=1), a falling SDA while SCL is high sets the busy flag (read bit 7). The flag is visible no later than 3 clock edges after the line change.
- R2: In I2C mode, a rising SDA while SCL is high clears the busy flag.
- R3: A write with bit 7=1 and bit 6=0 issues a start. The block releases SCL, pulls SDA low and then pulls SCL low. After that it holds SCL low (`sclOe`=1) and the busy flag reads 1. The same write while SCL is held low issues a repeated start.
- R4: A write with bit 6=1 issues no condition. `sclOe`, `sdaOe` and the busy flag stay as they were.
- R5: A write with bit 7=0 and bit 6=0 issues a stop. SDA is pulled low, SCL is released, and then SDA is released. The busy flag then reads 0 and `sclOe` is 0.
- R6: A read returns the busy flag in bit 7 and a constant 1 in bit 6. Bit 5 returns the current SDA drive state, where 1 means released. Bits 4 to 0 return 0.
- R7: A write with bit 4=0 stores bit 5 as the SDA level. Level 0 drives `sdaOe`=1 and level 1 releases SDA while no condition is being issued.
- R8: A write with bit 4=1 leaves the SDA level unchanged.
- R9: In clocked synchronous mode (`modeI2c`=0), line activity does not change the busy flag and issue writes start no condition.
- R10: During a start, SDA is pulled low exactly HOLD cycles before SCL is pulled low. During a stop, SCL is released exactly HOLD cycles before SDA is released.
- R11: An issue write that arrives while a condition is being generated is ignored.
- R12: After reset, a read returns 0x60 and both `sdaOe` and `sclOe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeI2c | input | 1 | 1 selects I2C format, 0 selects clocked synchronous format |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data |
| sdaIn | input | 1 | SDA line level, asynchronous |
| sclIn | input | 1 | SCL line level, asynchronous |
| sdaOe | output | 1 | 1 pulls SDA low |
| sclOe | output | 1 | 1 pulls SCL low |

## Verification
The bench builds the block with HOLD=3 and SYNC_STAGES=2. With these values a whole start or stop takes about ten cycles, and the bench can count the distance between the SDA and SCL transitions exactly. The bench models the wired-AND bus lines, so the block's own conditions come back through the synchroniser and drive the busy flag. This exposes the real loop between issuer and monitor, including the software-forced SDA low that the block itself sees as a start.

// File: rtl/i2c_busctl_pkg.sv
package i2c_busctl_pkg;

  // register bit positions
  localparam int BIT_BUSY    = 7;
  localparam int BIT_NOISSUE = 6;
  localparam int BIT_SDALVL  = 5;
  localparam int BIT_GUARD   = 4;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_ST_REL,   // start: both lines released
    SEQ_ST_SDA,   // start: SDA low, SCL high
    SEQ_ST_SCL,   // start: SDA low, SCL low
    SEQ_SP_SDA,   // stop: SDA low, SCL still low
    SEQ_SP_SCL,   // stop: SDA low, SCL released
    SEQ_SP_REL    // stop: both released
  } seqState_e;

  typedef struct packed {
    logic cntClear;
    logic sclPull;
    logic sclRelease;
    logic sdaLow;
    logic active;
  } ctlStrobe_t;

endpackage

// File: rtl/i2c_busctl_dp.sv
module i2c_busctl_dp
  import i2c_busctl_pkg::*;
#(
  parameter int HOLD        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeI2c,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       sdaIn,
  input  logic       sclIn,
  input  ctlStrobe_t strobe,
  output logic       issueStart,
  output logic       issueStop,
  output logic       cntDone,
  output logic       startSeen,
  output logic       stopSeen,
  output logic [7:0] rdData,
  output logic       sdaOe,
  output logic       sclOe
);

  localparam int CNT_W = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam int LINES = 2;

  logic [LINES-1:0] lineRaw;
  logic [LINES-1:0] lineNow;
  logic [LINES-1:0] linePrev;

  assign lineRaw = {sclIn, sdaIn};

  // one synchroniser chain per bus line
  for (genvar g = 0; g < LINES; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], lineRaw[g]};
    end
    assign lineNow[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linePrev <= '1;
    else       linePrev <= lineNow;
  end

  logic sdaNow, sdaPrev, sclNow, sclPrev;
  assign sdaNow  = lineNow[0];
  assign sclNow  = lineNow[1];
  assign sdaPrev = linePrev[0];
  assign sclPrev = linePrev[1];

  assign startSeen = sdaPrev & ~sdaNow & sclPrev & sclNow;
  assign stopSeen  = ~sdaPrev & sdaNow & sclPrev & sclNow;

  logic busyFlag;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      busyFlag <= 1'b0;
    else if (modeI2c && startSeen)  busyFlag <= 1'b1;
    else if (modeI2c && stopSeen)   busyFlag <= 1'b0;
  end

  logic sdaLvl;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             sdaLvl <= 1'b1;
    else if (wrEn && !wrData[BIT_GUARD])   sdaLvl <= wrData[BIT_SDALVL];
  end

  logic sclLow;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sclLow <= 1'b0;
    else if (strobe.sclPull)    sclLow <= 1'b1;
    else if (strobe.sclRelease) sclLow <= 1'b0;
  end

  logic [CNT_W-1:0] holdCnt;
  assign cntDone = (holdCnt == CNT_W'(HOLD - 1));
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdCnt <= '0;
    else if (strobe.cntClear) holdCnt <= '0;
    else if (!cntDone)        holdCnt <= holdCnt + 1'b1;
  end

  logic issueReq;
  assign issueReq   = wrEn & ~wrData[BIT_NOISSUE] & modeI2c & ~strobe.active;
  assign issueStart = issueReq & wrData[BIT_BUSY];
  assign issueStop  = issueReq & ~wrData[BIT_BUSY];

  assign sdaOe  = strobe.active ? strobe.sdaLow : ~sdaLvl;
  assign sclOe  = sclLow;
  assign rdData = {busyFlag, 1'b1, ~sdaOe, 5'b0};

endmodule

// File: rtl/i2c_busctl_ctl.sv
module i2c_busctl_ctl
  import i2c_busctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       issueStart,
  input  logic       issueStop,
  input  logic       cntDone,
  output ctlStrobe_t strobe
);

  seqState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    strobe.active = (state != SEQ_IDLE);
    unique case (state)
      SEQ_IDLE: begin
        if (issueStart) begin
          stateNext         = SEQ_ST_REL;
          strobe.cntClear   = 1'b1;
          strobe.sclRelease = 1'b1;
        end else if (issueStop) begin
          stateNext       = SEQ_SP_SDA;
          strobe.cntClear = 1'b1;
        end
      end
      SEQ_ST_REL: begin
        if (cntDone) begin
          stateNext       = SEQ_ST_SDA;
          strobe.cntClear = 1'b1;
        end
      end
      SEQ_ST_SDA: begin
        strobe.sdaLow = 1'b1;
        if (cntDone) begin
          stateNext       = SEQ_ST_SCL;
          strobe.cntClear = 1'b1;
          strobe.sclPull  = 1'b1;
        end
      end
      SEQ_ST_SCL: begin
        strobe.sdaLow = 1'b1;
        if (cntDone) stateNext = SEQ_IDLE;
      end
      SEQ_SP_SDA: begin
        strobe.sdaLow = 1'b1;
        if (cntDone) begin
          stateNext         = SEQ_SP_SCL;
          strobe.cntClear   = 1'b1;
          strobe.sclRelease = 1'b1;
        end
      end
      SEQ_SP_SCL: begin
        strobe.sdaLow = 1'b1;
        if (cntDone) begin
          stateNext       = SEQ_SP_REL;
          strobe.cntClear = 1'b1;
        end
      end
      SEQ_SP_REL: begin
        if (cntDone) stateNext = SEQ_IDLE;
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

endmodule

// File: rtl/i2c_busctl_top.sv
module i2c_busctl_top
  import i2c_busctl_pkg::*;
#(
  parameter int HOLD        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeI2c,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       sdaIn,
  input  logic       sclIn,
  output logic       sdaOe,
  output logic       sclOe
);

  ctlStrobe_t strobe;
  logic issueStart, issueStop, cntDone;
  logic startSeen, stopSeen, seqActive;

  assign seqActive = strobe.active;

  i2c_busctl_dp #(.HOLD(HOLD), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .modeI2c(modeI2c), .wrEn(wrEn), .wrData(wrData),
    .sdaIn(sdaIn), .sclIn(sclIn), .strobe(strobe),
    .issueStart(issueStart), .issueStop(issueStop), .cntDone(cntDone),
    .startSeen(startSeen), .stopSeen(stopSeen),
    .rdData(rdData), .sdaOe(sdaOe), .sclOe(sclOe)
  );

  i2c_busctl_ctl uCtl (
    .clk(clk), .rstN(rstN), .issueStart(issueStart), .issueStop(issueStop),
    .cntDone(cntDone), .strobe(strobe)
  );

endmodule

// File: rtl/i2c_busctl_chk.sv
module i2c_busctl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       modeI2c,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       sdaOe,
  input logic       sclOe,
  input logic       startSeen,
  input logic       stopSeen,
  input logic       seqActive
);

  assert_start_sets_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    (modeI2c && startSeen) |=> rdData[7]);

  assert_stop_clears_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeI2c && stopSeen && !startSeen) |=> !rdData[7]);

  assert_issue_needs_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqActive) |-> $past(wrEn && !wrData[6] && modeI2c));

  assert_sync_busy_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!modeI2c && $past(!modeI2c)) |-> $stable(rdData[7]));

  assert_scl_pull_under_sda_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclOe) |-> sdaOe);

endmodule

bind i2c_busctl_top i2c_busctl_chk uChk (
  .clk(clk), .rstN(rstN), .modeI2c(modeI2c), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .sdaOe(sdaOe), .sclOe(sclOe), .startSeen(startSeen),
  .stopSeen(stopSeen), .seqActive(seqActive)
);

// File: tb/tb_i2c_busctl_top.sv
`timescale 1ns/1ps
module tb_i2c_busctl_top;

  localparam int HOLD   = 3;
  localparam int SETTLE = 3 * HOLD + 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeI2c = 1'b1;
  logic wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic sdaOe, sclOe;
  logic extSdaLow = 1'b0;
  logic sdaLine, sclLine;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  assign sdaLine = ~(sdaOe | extSdaLow);
  assign sclLine = ~sclOe;

  i2c_busctl_top #(.HOLD(HOLD), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .modeI2c(modeI2c), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .sdaIn(sdaLine), .sclIn(sclLine), .sdaOe(sdaOe), .sclOe(sclOe)
  );

  // op: 0 register write, 1 external start, 2 external stop, 3 set mode (val[0])
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] val;
    logic [7:0] expRd;
    logic       expScl;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 8'h00, 8'hE0, 1'b0, 4'd1},  // R1 external start
    '{2'd2, 8'h00, 8'h60, 1'b0, 4'd2},  // R2 external stop
    '{2'd0, 8'h40, 8'hC0, 1'b0, 4'd7},  // R7 SDA forced low, seen as start
    '{2'd0, 8'h60, 8'h60, 1'b0, 4'd7},  // R7 SDA released, seen as stop
    '{2'd0, 8'h50, 8'h60, 1'b0, 4'd8},  // R8 guard set, level kept
    '{2'd0, 8'hB0, 8'hE0, 1'b1, 4'd3},  // R3 start issued
    '{2'd0, 8'hF0, 8'hE0, 1'b1, 4'd4},  // R4 disable bit set, nothing issued
    '{2'd0, 8'hB0, 8'hE0, 1'b1, 4'd3},  // R3 repeated start
    '{2'd0, 8'h30, 8'h60, 1'b0, 4'd5},  // R5 stop issued
    '{2'd3, 8'h00, 8'h60, 1'b0, 4'd9},  // R9 clocked synchronous mode
    '{2'd1, 8'h00, 8'h60, 1'b0, 4'd9},  // R9 line start ignored
    '{2'd2, 8'h00, 8'h60, 1'b0, 4'd9},  // R9 line stop ignored
    '{2'd0, 8'hB0, 8'h60, 1'b0, 4'd9},  // R9 issue write ignored
    '{2'd3, 8'h01, 8'h60, 1'b0, 4'd6}   // R6 back to I2C, read format
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state, R6 read format
    check("R12 rdData", 32'(rdData), 32'h60);
    check("R12 sdaOe", 32'(sdaOe), 32'h0);
    check("R12 sclOe", 32'(sclOe), 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VECS[i];
      case (v.op)
        2'd0: regWrite(v.val);
        2'd1: begin @(negedge clk); extSdaLow = 1'b1; end
        2'd2: begin @(negedge clk); extSdaLow = 1'b0; end
        default: begin @(negedge clk); modeI2c = v.val[0]; end
      endcase
      settle();
      check($sformatf("R%0d rdData vec%0d", v.req, i), 32'(rdData), 32'(v.expRd));
      check($sformatf("R%0d sclOe vec%0d", v.req, i), 32'(sclOe), 32'(v.expScl));
    end

    // R1 latency: busy visible within 3 clock edges of the line change
    @(negedge clk);
    extSdaLow = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 busy latency", 32'(rdData[7]), 32'h1);
    extSdaLow = 1'b0;
    settle();
    check("R2 busy cleared", 32'(rdData[7]), 32'h0);

    // R10 start timing: SDA low to SCL low spacing
    begin
      int tSda = -1;
      int tScl = -1;
      regWrite(8'hB0);
      for (int c = 0; c < 60; c++) begin
        if (tSda < 0 && sdaOe) tSda = c;
        if (tScl < 0 && sclOe) tScl = c;
        @(negedge clk);
      end
      check("R10 start spacing", 32'(tScl - tSda), 32'(HOLD));
      check("R3 busy after start", 32'(rdData[7]), 32'h1);
    end

    // R10 stop timing: SCL release to SDA release spacing
    begin
      int tScl = -1;
      int tSda = -1;
      regWrite(8'h30);
      for (int c = 0; c < 60; c++) begin
        if (tScl < 0 && !sclOe) tScl = c;
        if (tScl >= 0 && tSda < 0 && !sdaOe && c > tScl) tSda = c;
        @(negedge clk);
      end
      check("R10 stop spacing", 32'(tSda - tScl), 32'(HOLD));
      check("R5 busy after stop", 32'(rdData[7]), 32'h0);
    end

    // R11 stop write during an active start is ignored
    regWrite(8'hB0);
    regWrite(8'h30);
    settle();
    check("R11 scl held", 32'(sclOe), 32'h1);
    check("R11 busy kept", 32'(rdData[7]), 32'h1);
    regWrite(8'h30);
    settle();
    check("R5 final stop", 32'(rdData), 32'h60);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule